// File: doc/BRIEF.md
# Pulse-Width Waveform Generator with Counted Single Runs

The block turns a clock into a periodic two-level waveform. Each period is `period_i + 1` clock cycles long. It starts with a first phase whose level is chosen by `first_lvl_i`, and the rest of the period is driven at the opposite level. The first-phase length is `duty_i` cycles. A one-cycle `event_o` pulse marks the last cycle of every period, so it can serve as an interrupt or as a DMA request.

There are two modes. In free-running mode the waveform repeats for as long as `enable_i` stays high. In counted mode the block waits for a trigger, which is either a software pulse or a rising edge on a frame-sync input. It then emits exactly `repeat_i + 1` periods, raises `done_o` together with the final `event_o`, and returns to the idle level. The period, duty and polarity inputs are captured only at a period boundary, so software may rewrite them at any time without producing a malformed period.

Top module: `pulse_gen`

## Requirements
- R1: Whenever no waveform is being generated, `pwm_o` equals `idle_lvl_i` and `event_o` and `done_o` are 0. This covers reset, `enable_i` low, and counted mode waiting for a trigger or after finishing.
- R2: A period lasts `period_i + 1` cycles, with position 0 to `period_i`. Positions below `duty_i` are driven at `first_lvl_i` and the others at its inverse. With `duty_i = 0` the whole period is inverted, and with `duty_i > period_i` the whole period is at `first_lvl_i`. The position never exceeds the captured period.
- R3: With `enable_i = 1` and `oneshot_i = 0`, generation starts at the next clock edge at position 0. Periods then follow back to back until `enable_i` falls.
- R4: In counted mode (`oneshot_i = 1`) a trigger starts exactly `repeat_i + 1` periods, with `repeat_i` 8 bits wide (255 gives 256 periods). The output then returns to the idle level.
- R5: A trigger is `start_i` high at a clock edge, or a 0-to-1 change of `sync_i` between two edges while `sync_en_i = 1`. It acts only while idle with `enable_i = 1` and `oneshot_i = 1`. A held-high `sync_i` does not trigger again, and `sync_i` edges are ignored while `sync_en_i = 0`.
- R6: A trigger that arrives while a counted run is in progress, including in its final cycle, neither extends nor restarts the run.
- R7: `event_o` is high for exactly the last cycle of every generated period. `done_o` is high only in the last cycle of the final period of a counted run.
- R8: `period_i`, `duty_i` and `first_lvl_i` are captured when generation starts and at each period boundary. Changes made mid-period first affect the next period.
- R9: When `enable_i` is low at a clock edge, generation stops: from the next cycle `pwm_o` is at the idle level and `event_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Generator enable |
| oneshot_i | input | 1 | 1 = counted mode, 0 = free-running mode |
| start_i | input | 1 | Software trigger for counted mode |
| sync_i | input | 1 | Frame-sync input; a rising edge triggers |
| sync_en_i | input | 1 | Allows `sync_i` edges to trigger |
| period_i | input | 32 | Period length minus one, in cycles |
| duty_i | input | 32 | First-phase length in cycles |
| first_lvl_i | input | 1 | Output level during the first phase |
| idle_lvl_i | input | 1 | Output level while not generating |
| repeat_i | input | 8 | Counted run length minus one, in periods |
| pwm_o | output | 1 | Waveform output |
| event_o | output | 1 | One-cycle pulse on the last cycle of each period |
| done_o | output | 1 | One-cycle pulse on the last cycle of a counted run |

## Verification
The waveform is compared cycle by cycle in several settings. A mid-range duty separates correct phase order from swapped polarity. Zero and over-length duties expose off-by-one errors in the phase comparison. A single-cycle period with the largest repeat count shows whether the 8-bit count is honoured in full. The trigger sources are exercised separately: a software pulse, a sync edge, a held sync level, a sync edge while sync is masked, and retriggers during a run and in its final cycle. Each one tells apart an edge-detect fault, a missing mask or a run that restarts. A mid-period rewrite of period and duty checks that capture happens only at the boundary and not immediately.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} gen_state_e;
endpackage

// File: rtl/pulse_gen_trig.sv
module pulse_gen_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sync_i,
  input  logic sync_en_i,
  output logic trig_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign trig_o = start_i | (sync_en_i & sync_i & ~sync_q);
endmodule

// File: rtl/pulse_gen_seq.sv
module pulse_gen_seq
  import pulse_gen_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          oneshot_i,
  input  logic          trig_i,
  input  logic          wrap_i,
  input  logic [RW-1:0] repeat_i,
  output logic          run_o,
  output logic          mode_o,
  output logic [RW-1:0] rep_o,
  output logic          load_o,
  output logic          adv_o
);
  gen_state_e    state_q;
  logic          mode_q;
  logic [RW-1:0] rep_q;
  logic          running, last, start, reload;

  assign running = (state_q == ST_RUN);
  assign last    = mode_q && (rep_q == '0);
  assign start   = !running && enable_i && (!oneshot_i || trig_i);
  assign reload  = running && enable_i && wrap_i && !last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      rep_q   <= '0;
    end else if (start) begin
      state_q <= ST_RUN;
      mode_q  <= oneshot_i;
      rep_q   <= repeat_i;
    end else if (running) begin
      if (!enable_i || (wrap_i && last)) state_q <= ST_IDLE;
      else if (reload && mode_q)         rep_q   <= rep_q - 1'b1;
    end
  end

  assign run_o  = running;
  assign mode_o = mode_q;
  assign rep_o  = rep_q;
  assign load_o = start | reload;
  assign adv_o  = running & enable_i & ~wrap_i;
endmodule

// File: rtl/pulse_gen_cnt.sv
module pulse_gen_cnt #(
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] duty_i,
  input  logic          first_lvl_i,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] per_o,
  output logic [PW-1:0] duty_o,
  output logic          lvl_o,
  output logic          wrap_o,
  output logic          first_o
);
  logic [PW-1:0] cnt_q, per_q, duty_q;
  logic          lvl_q;

  // shadow values move only on load, i.e. start or period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      lvl_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      duty_q <= duty_i;
      lvl_q  <= first_lvl_i;
    end else if (adv_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end else begin
      cnt_q  <= '0;
    end
  end

  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign duty_o  = duty_q;
  assign lvl_o   = lvl_q;
  assign wrap_o  = (cnt_q == per_q);
  assign first_o = (cnt_q < duty_q);
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter int PW = 32,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          oneshot_i,
  input  logic          start_i,
  input  logic          sync_i,
  input  logic          sync_en_i,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] duty_i,
  input  logic          first_lvl_i,
  input  logic          idle_lvl_i,
  input  logic [RW-1:0] repeat_i,
  output logic          pwm_o,
  output logic          event_o,
  output logic          done_o
);
  logic          trig, run, mode, load, adv, wrap, first, lvl;
  logic [RW-1:0] rep;
  logic [PW-1:0] cnt, per, duty;

  pulse_gen_trig u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sync_i    (sync_i),
    .sync_en_i (sync_en_i),
    .trig_o    (trig)
  );

  pulse_gen_seq #(.RW(RW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .oneshot_i (oneshot_i),
    .trig_i    (trig),
    .wrap_i    (wrap),
    .repeat_i  (repeat_i),
    .run_o     (run),
    .mode_o    (mode),
    .rep_o     (rep),
    .load_o    (load),
    .adv_o     (adv)
  );

  pulse_gen_cnt #(.PW(PW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .adv_i       (adv),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .first_lvl_i (first_lvl_i),
    .cnt_o       (cnt),
    .per_o       (per),
    .duty_o      (duty),
    .lvl_o       (lvl),
    .wrap_o      (wrap),
    .first_o     (first)
  );

  assign pwm_o   = run ? (first ? lvl : ~lvl) : idle_lvl_i;
  assign event_o = run & wrap;
  assign done_o  = event_o & mode & (rep == '0);
endmodule

// File: rtl/pulse_gen_chk.sv
module pulse_gen_chk #(
  parameter int PW = 32,
  parameter int RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          idle_lvl_i,
  input logic          pwm_o,
  input logic          event_o,
  input logic          done_o,
  input logic          run_i,
  input logic          mode_i,
  input logic [RW-1:0] rep_i,
  input logic [PW-1:0] cnt_i,
  input logic [PW-1:0] per_i,
  input logic [PW-1:0] duty_i,
  input logic          lvl_i
);
  AST_DISABLE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pwm_o == idle_lvl_i) && !event_o) else $error("disable"); // R9

  AST_POS_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= per_i)) else $error("position"); // R2

  AST_RESTART_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !done_o && enable_i) |=> run_i && (cnt_i == '0)) else $error("wrap"); // R3

  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !event_o) |=> $stable(per_i) && $stable(duty_i) && $stable(lvl_i))
    else $error("shadow"); // R8

  AST_RUN_NOT_RETRIGGERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i && !event_o && enable_i) |=> run_i && $stable(rep_i))
    else $error("retrigger"); // R6

  AST_DONE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_i && !event_o) else $error("done"); // R4
endmodule

bind pulse_gen pulse_gen_chk #(.PW(PW), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .idle_lvl_i (idle_lvl_i),
  .pwm_o      (pwm_o),
  .event_o    (event_o),
  .done_o     (done_o),
  .run_i      (run),
  .mode_i     (mode),
  .rep_i      (rep),
  .cnt_i      (cnt),
  .per_i      (per),
  .duty_i     (duty),
  .lvl_i      (lvl)
);

// File: tb/pulse_gen_bench.sv
module pulse_gen_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, oneshot = 1'b0, start = 1'b0, sync = 1'b0, sync_en = 1'b0;
  logic [31:0] period = '0, duty = '0;
  logic        first_lvl = 1'b0, idle_lvl = 1'b0;
  logic [7:0]  rep = '0;
  logic        pwm, evt, done;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_gen u_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .oneshot_i(oneshot),
    .start_i(start), .sync_i(sync), .sync_en_i(sync_en), .period_i(period),
    .duty_i(duty), .first_lvl_i(first_lvl), .idle_lvl_i(idle_lvl),
    .repeat_i(rep), .pwm_o(pwm), .event_o(evt), .done_o(done)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiesce();
    enable = 0; oneshot = 0; start = 0; sync = 0; sync_en = 0;
    step(); step();
  endtask

  task automatic t_reset();
    idle_lvl = 1;
    #3;
    check("R1", "pwm in reset", pwm, 1);
    rst_n = 1;
    step();
    check("R1", "pwm after reset", pwm, 1);
    check("R1", "event after reset", evt, 0);
    check("R1", "done after reset", done, 0);
  endtask

  task automatic t_continuous();
    period = 4; duty = 2; first_lvl = 1; idle_lvl = 0;
    enable = 1; oneshot = 0;
    step();
    for (int k = 0; k < 15; k++) begin
      check("R2", "cont pwm", pwm, (k % 5) < 2);
      check("R7", "cont event", evt, (k % 5) == 4);
      check("R3", "cont done", done, 0);
      step();
    end
    enable = 0;
    step();
    check("R9", "pwm after disable", pwm, 0);
    check("R9", "event after disable", evt, 0);
    step();
    check("R9", "pwm stays idle", pwm, 0);
    quiesce();
  endtask

  task automatic t_duty_edges();
    period = 2; duty = 0; first_lvl = 0; idle_lvl = 0;
    enable = 1;
    step();
    for (int k = 0; k < 6; k++) begin
      check("R2", "duty0 pwm", pwm, 1);
      check("R2", "duty0 event", evt, (k % 3) == 2);
      step();
    end
    quiesce();
    duty = 7; idle_lvl = 1;
    enable = 1;
    step();
    for (int k = 0; k < 6; k++) begin
      check("R2", "long duty pwm", pwm, 0);
      check("R2", "long duty event", evt, (k % 3) == 2);
      step();
    end
    quiesce();
  endtask

  task automatic t_oneshot_sw();
    period = 2; duty = 1; first_lvl = 0; idle_lvl = 1; rep = 2;
    enable = 1; oneshot = 1;
    step(); step();
    check("R1", "waiting pwm", pwm, 1);
    check("R1", "waiting event", evt, 0);
    start = 1;
    step();
    start = 0;
    for (int k = 0; k < 13; k++) begin
      if (k < 9) begin
        check("R4", "oneshot pwm", pwm, (k % 3) < 1 ? 0 : 1);
        check("R7", "oneshot event", evt, (k % 3) == 2);
        check("R7", "oneshot done", done, k == 8);
      end else begin
        check("R1", "finished pwm", pwm, 1);
        check("R1", "finished event", evt, 0);
      end
      step();
    end
    quiesce();
  endtask

  task automatic t_retrigger();
    period = 3; duty = 2; first_lvl = 1; idle_lvl = 0; rep = 1;
    enable = 1; oneshot = 1;
    start = 1;
    step();
    start = 0;
    for (int k = 0; k < 12; k++) begin
      if (k < 8) begin
        check("R6", "retrig pwm", pwm, (k % 4) < 2);
        check("R6", "retrig event", evt, (k % 4) == 3);
        check("R6", "retrig done", done, k == 7);
      end else begin
        check("R6", "no restart pwm", pwm, 0);
        check("R6", "no restart event", evt, 0);
      end
      start = (k == 2 || k == 7);
      step();
    end
    start = 0;
    quiesce();
  endtask

  task automatic t_sync();
    period = 1; duty = 1; first_lvl = 1; idle_lvl = 0; rep = 0;
    enable = 1; oneshot = 1; sync_en = 1; sync = 0;
    step();
    sync = 1;
    step();
    for (int k = 0; k < 6; k++) begin
      if (k < 2) begin
        check("R5", "sync pwm", pwm, k < 1);
        check("R5", "sync event", evt, k == 1);
        check("R5", "sync done", done, k == 1);
      end else begin
        check("R5", "held sync pwm", pwm, 0);
        check("R5", "held sync event", evt, 0);
      end
      step();
    end
    sync_en = 0; sync = 0;
    step();
    sync = 1;
    step();
    for (int k = 0; k < 4; k++) begin
      check("R5", "masked sync pwm", pwm, 0);
      check("R5", "masked sync event", evt, 0);
      step();
    end
    quiesce();
  endtask

  task automatic t_shadow();
    period = 3; duty = 1; first_lvl = 1; idle_lvl = 0;
    enable = 1; oneshot = 0;
    step();
    for (int k = 0; k < 10; k++) begin
      check("R8", "shadow pwm", pwm, (k < 4) ? (k < 1) : ((k - 4) < 3));
      check("R8", "shadow event", evt, (k == 3) || (k == 9));
      if (k == 1) begin
        period = 5; duty = 3;
      end
      step();
    end
    quiesce();
  endtask

  task automatic t_max_repeat();
    int n_evt = 0, done_at = -1, n_hi = 0;
    period = 0; duty = 1; first_lvl = 1; idle_lvl = 0; rep = 255;
    enable = 1; oneshot = 1;
    start = 1;
    step();
    start = 0;
    for (int k = 0; k < 260; k++) begin
      if (evt) n_evt++;
      if (pwm) n_hi++;
      if (done) done_at = k;
      step();
    end
    check("R4", "event count for 255", n_evt, 256);
    check("R4", "high cycles for 255", n_hi, 256);
    check("R4", "done cycle for 255", done_at, 255);
    check("R1", "idle after long run", pwm, 0);
    quiesce();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_continuous();
    t_duty_edges();
    t_oneshot_sw();
    t_retrigger();
    t_sync();
    t_shadow();
    t_max_repeat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule